// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host-side master for a small 8-bit successive-approximation converter that has a three-wire link: a convert-start line, a serial clock and a serial data return. A requester asks for one reading and gives a channel bit. The controller then drives the start line to select the channel. A single falling edge starts a conversion on channel 0. A second high/low pulse moves the converter to channel 1. The controller waits out the converter's internal conversion time and then clocks the 8-bit result in, most significant bit first. It returns the byte with a one-cycle valid strobe and the channel tag.

Every interval is a parameter counted in system clock cycles. The clock period in picoseconds is also a parameter, and the built-in assertions use it to compare each interval the controller actually produces with the physical minimum the converter needs. Two bit parameters select the idle level of the start line and the idle level of the serial clock, so the block covers both clock-polarity modes used with such converters. The converter shifts data on the serial-clock falling edge, and the controller always captures on the rising edge that closes each of the 8 clock cycles.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1, `rsp_valid` is 0, `conv_o` sits at `CNV_IDLE_HIGH` and `sck_o` sits at `SCK_IDLE_HIGH`.
- R2: A read with `req_chan`=0 produces exactly one falling edge on `conv_o`. The line is first held high for `T_CNV_HI` cycles.
- R3: A read with `req_chan`=1 produces exactly two falling edges on `conv_o`. The first low interval lasts `T_CNV_LO` cycles and the second high interval lasts `T_CNV_HI` cycles.
- R4: Every high and every low interval of `conv_o` lasts at least 100 ns.
- R5: No edge appears on `sck_o` until `T_CONV` cycles (at least 7.5 µs) after the last falling edge of `conv_o`.
- R6: Each read produces exactly 8 rising edges on `sck_o`. Low phases last `T_SCK_LO` cycles and high phases `T_SCK_HI` cycles, each phase at least 75 ns and each period at least 200 ns. Between reads `sck_o` rests at `SCK_IDLE_HIGH`.
- R7: `sdi_i` is captured at each rising edge of `sck_o`. The first bit captured becomes bit 7 of `rsp_data`, and the result is the unsigned code the converter sent.
- R8: At least `T_GAP` cycles (at least 50 ns) separate the last `sck_o` edge of a read from the next edge on `conv_o`.
- R9: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` then stays low and further requests are ignored until `rsp_valid` pulses for exactly one cycle, with `rsp_chan` equal to the accepted channel. This happens T_CNV_HI+T_CNV_LO+T_CONV+8·(T_SCK_LO+T_SCK_HI)+T_GAP cycles after the accepting edge, plus T_CNV_HI more for channel 1.
- R10: In the cycle `rsp_valid` is high, `conv_o` has returned to its idle level and `req_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_chan | input | 1 | Channel to read (0 or 1) |
| req_ready | output | 1 | Controller idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle strobe marking a finished read |
| rsp_data | output | DATA_W | Captured conversion code |
| rsp_chan | output | 1 | Channel the code belongs to |
| conv_o | output | 1 | Convert-start line to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| sdi_i | input | 1 | Serial data from the converter |

## Verification
With the default parameters, a channel-0 result is due 1171 cycles after the accepting edge and a channel-1 result 1184 cycles after it. The scoreboard records the cycle number of acceptance and checks the response latency exactly. Start-line falling edges, serial-clock rising edges and the conversion wait are counted by a converter model that samples on the falling system-clock edge, half a cycle after the registered outputs move. Every result is compared in the cycle its strobe is high, and the strobe's absence is checked one cycle later. Two instances run side by side, one with both lines idling low and one with both idling high, so both clock-polarity modes are checked against the same expected bytes and latencies.

// File: rtl/adc_rd_pkg.sv
// Shared types and helpers for the serial converter read controller.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package adc_rd_pkg;

    // Phases of one read transaction.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,     // start line high before the first falling edge
        ST_LO1,     // first low interval
        ST_HI2,     // second high pulse (channel 1 only)
        ST_CONV,    // conversion wait, start line low
        ST_SLO,     // serial clock low phase
        ST_SHI,     // serial clock high phase
        ST_GAP      // spacing before the start line may move again
    } rd_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Cycles needed to cover a duration given in picoseconds (rounded up).
    function automatic int ps_to_cyc(input int dur_ps, input int clk_ps);
        return (dur_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
// Loadable down counter used to time every phase of a read.
// Assumes the loaded value is the phase length minus one; expired is high
// in the last cycle of the phase.
module adc_rd_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    // Count down to zero and hold there; a load restarts the phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_shifter.sv
// Serial-in capture register: shifts one bit in from the right on each
// enable, so the first bit captured ends up in the top position.
// Assumes exactly W enables per transaction.
module adc_rd_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    // Capture the serial bit MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (shift_en)
            q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
// Host-side read controller for a three-wire 8-bit converter.
// Runs one read per accepted request: start pulse(s) select the channel,
// a fixed wait covers the conversion, then DATA_W serial clocks capture the
// code MSB first on rising edges. All intervals are in system clock cycles;
// CLK_PS is used only by the assertions to check the physical minimums.
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int CLK_PS        = 8000,
    parameter int T_CNV_HI      = 13,
    parameter int T_CNV_LO      = 13,
    parameter int T_CONV        = 938,
    parameter int T_SCK_LO      = 13,
    parameter int T_SCK_HI      = 12,
    parameter int T_GAP         = 7,
    parameter bit CNV_IDLE_HIGH = 1'b0,
    parameter bit SCK_IDLE_HIGH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_chan,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_chan,
    output logic              conv_o,
    output logic              sck_o,
    input  logic              sdi_i
);
    localparam int TMAX = max2(max2(max2(T_CNV_HI, T_CNV_LO), max2(T_CONV, T_GAP)),
                               max2(max2(T_SCK_LO, T_SCK_HI), 2));
    localparam int CW   = $clog2(TMAX);
    localparam int BW   = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    rd_state_t     state_q, state_d;
    logic [BW-1:0] bit_q, bit_d;
    logic          chan_q, chan_d;
    logic          rsp_q, rsp_d;
    logic          conv_q, conv_d;
    logic          sck_q, sck_d;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          sample;

    adc_rd_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    adc_rd_shifter #(.W(DATA_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample),
        .din      (sdi_i),
        .q        (rsp_data)
    );

    // Next phase, timer reload and capture strobe.
    always_comb begin
        state_d  = state_q;
        bit_d    = bit_q;
        chan_d   = chan_q;
        rsp_d    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sample   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                state_d  = ST_PRE;
                chan_d   = req_chan;
                tmr_load = 1'b1;
                tmr_val  = CW'(T_CNV_HI - 1);
            end
            ST_PRE: if (tmr_done) begin
                state_d  = ST_LO1;
                tmr_load = 1'b1;
                tmr_val  = CW'(T_CNV_LO - 1);
            end
            ST_LO1: if (tmr_done) begin
                tmr_load = 1'b1;
                if (chan_q) begin
                    state_d = ST_HI2;
                    tmr_val = CW'(T_CNV_HI - 1);
                end else begin
                    state_d = ST_CONV;
                    tmr_val = CW'(T_CONV - 1);
                end
            end
            ST_HI2: if (tmr_done) begin
                state_d  = ST_CONV;
                tmr_load = 1'b1;
                tmr_val  = CW'(T_CONV - 1);
            end
            ST_CONV: if (tmr_done) begin
                state_d  = ST_SLO;
                bit_d    = '0;
                tmr_load = 1'b1;
                tmr_val  = CW'(T_SCK_LO - 1);
            end
            ST_SLO: if (tmr_done) begin
                state_d  = ST_SHI;
                sample   = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = CW'(T_SCK_HI - 1);
            end
            ST_SHI: if (tmr_done) begin
                tmr_load = 1'b1;
                if (bit_q == LAST_BIT) begin
                    state_d = ST_GAP;
                    tmr_val = CW'(T_GAP - 1);
                end else begin
                    state_d = ST_SLO;
                    bit_d   = bit_q + 1'b1;
                    tmr_val = CW'(T_SCK_LO - 1);
                end
            end
            ST_GAP: if (tmr_done) begin
                state_d = ST_IDLE;
                rsp_d   = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Line levels for the coming phase, so both outputs leave flops.
    always_comb begin
        unique case (state_d)
            ST_IDLE:        conv_d = CNV_IDLE_HIGH;
            ST_PRE, ST_HI2: conv_d = 1'b1;
            default:        conv_d = 1'b0;
        endcase
        unique case (state_d)
            ST_SHI:  sck_d = 1'b1;
            ST_SLO:  sck_d = 1'b0;
            default: sck_d = SCK_IDLE_HIGH;
        endcase
    end

    // Register phase, bit index, channel tag, strobe and line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            chan_q  <= 1'b0;
            rsp_q   <= 1'b0;
            conv_q  <= CNV_IDLE_HIGH;
            sck_q   <= SCK_IDLE_HIGH;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            chan_q  <= chan_d;
            rsp_q   <= rsp_d;
            conv_q  <= conv_d;
            sck_q   <= sck_d;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = rsp_q;
    assign rsp_chan  = chan_q;
    assign conv_o    = conv_q;
    assign sck_o     = sck_q;

    // ------------------------------------------------------------------
    // Assertions: measured intervals against physical minimums.
    // ------------------------------------------------------------------
    localparam int MIN_CNV_PH  = ps_to_cyc(100000, CLK_PS);
    localparam int MIN_CONV    = ps_to_cyc(7500000, CLK_PS);
    localparam int MIN_SCK_PH  = ps_to_cyc(75000, CLK_PS);
    localparam int MIN_SCK_PER = ps_to_cyc(200000, CLK_PS);
    localparam int MIN_GAP     = ps_to_cyc(50000, CLK_PS);

    logic [15:0] cnv_hi_run, cnv_lo_run, since_cfall, since_sedge;
    logic [15:0] sck_hi_run, sck_lo_run, sck_per_run;
    logic [3:0]  rise_cnt;
    logic        conv_p, sck_p;

    // Saturating interval counters observed on the output pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_hi_run  <= '1;
            cnv_lo_run  <= '1;
            since_cfall <= '1;
            since_sedge <= '1;
            sck_hi_run  <= '1;
            sck_lo_run  <= '1;
            sck_per_run <= '1;
            rise_cnt    <= '0;
            conv_p      <= CNV_IDLE_HIGH;
            sck_p       <= SCK_IDLE_HIGH;
        end else begin
            conv_p <= conv_o;
            sck_p  <= sck_o;
            cnv_hi_run  <= conv_o ? ((cnv_hi_run == '1) ? cnv_hi_run : cnv_hi_run + 1'b1) : '0;
            cnv_lo_run  <= !conv_o ? ((cnv_lo_run == '1) ? cnv_lo_run : cnv_lo_run + 1'b1) : '0;
            sck_hi_run  <= sck_o ? ((sck_hi_run == '1) ? sck_hi_run : sck_hi_run + 1'b1) : '0;
            sck_lo_run  <= !sck_o ? ((sck_lo_run == '1) ? sck_lo_run : sck_lo_run + 1'b1) : '0;
            if (conv_p && !conv_o)
                since_cfall <= 16'd1;
            else if (since_cfall != '1)
                since_cfall <= since_cfall + 1'b1;
            if (sck_p != sck_o)
                since_sedge <= 16'd1;
            else if (since_sedge != '1)
                since_sedge <= since_sedge + 1'b1;
            if (!sck_p && sck_o)
                sck_per_run <= 16'd1;
            else if (sck_per_run != '1)
                sck_per_run <= sck_per_run + 1'b1;
            if (req_valid && req_ready)
                rise_cnt <= '0;
            else if (!sck_p && sck_o)
                rise_cnt <= rise_cnt + 1'b1;
        end
    end

    a_r4_cnv_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_o) |-> cnv_hi_run >= 16'(MIN_CNV_PH));
    a_r4_cnv_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_o) |-> cnv_lo_run >= 16'(MIN_CNV_PH));
    a_r5_conv_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o != $past(sck_o)) |-> since_cfall >= 16'(MIN_CONV));
    a_r6_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck_o) |-> sck_hi_run >= 16'(MIN_SCK_PH));
    a_r6_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> sck_lo_run >= 16'(MIN_SCK_PH));
    a_r6_sck_period: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> sck_per_run >= 16'(MIN_SCK_PER));
    a_r6_eight_rises: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rise_cnt == 4'(DATA_W));
    a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_o != $past(conv_o)) |-> since_sedge >= 16'(MIN_GAP));
    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (conv_o == CNV_IDLE_HIGH) && req_ready);
endmodule

// File: tb/tb_adc_rd_ctrl.sv
`timescale 1ns/1ps

// Behavioural converter model: counts start falls and clock rises, picks the
// code by channel, shifts on clock falling edges, measures the conversion
// wait and the clock-to-start gap in system cycles (sampled on negedge clk).
module adc_dev_model (
    input  logic       clk,
    input  logic       conv,
    input  logic       sck,
    input  logic       clr,
    input  logic [7:0] code0,
    input  logic [7:0] code1,
    output logic       sdo,
    output int         falls,
    output int         rises,
    output int         wait_cyc,
    output int         min_gap
);
    logic conv_p, sck_p;
    bit   armed, waiting, seen_s;
    int   idx, since_f, since_s;
    logic [7:0] sel;

    initial begin
        falls = 0; rises = 0; wait_cyc = 0; min_gap = 1000000;
        idx = 0; since_f = 0; since_s = 0; sdo = 1'b0;
        armed = 0; waiting = 0; seen_s = 0; conv_p = 1'b0; sck_p = 1'b0;
    end

    // Track pin activity one half cycle after each system clock edge.
    always @(negedge clk) begin
        if (!armed) begin
            armed = 1;
        end else begin
            if (clr) begin falls = 0; rises = 0; end
            since_f++;
            since_s++;
            if (conv_p && !conv) begin
                falls++; idx = 0; since_f = 0; waiting = 1;
            end
            if (conv != conv_p && seen_s && since_s < min_gap) min_gap = since_s;
            if (sck != sck_p) begin
                if (waiting) begin wait_cyc = since_f; waiting = 0; end
                since_s = 0; seen_s = 1;
            end
            if (!sck_p && sck) rises++;
            if (sck_p && !sck) idx = rises;
        end
        conv_p = conv;
        sck_p  = sck;
        sel = (falls >= 2) ? code1 : code0;
        sdo = (idx < 8) ? sel[7 - idx] : 1'b0;
    end
endmodule

module tb_adc_rd_ctrl;
    localparam int P_HI = 13, P_LO = 13, P_CONV = 938, P_SL = 13, P_SH = 12, P_GAP = 7;
    localparam int L0 = P_HI + P_LO + P_CONV + 8 * (P_SL + P_SH) + P_GAP;
    localparam int L1 = L0 + P_HI;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_chan = 1'b0, clr = 1'b0;
    logic [7:0] code0 = 8'h00, code1 = 8'h00;

    logic       rdy_a, val_a, ch_a, conv_a, sck_a, sdi_a;
    logic       rdy_b, val_b, ch_b, conv_b, sck_b, sdi_b;
    logic [7:0] dat_a, dat_b;
    int falls_a, rises_a, wait_a, gap_a, falls_b, rises_b, wait_b, gap_b;

    int checks = 0, errors = 0, cyc = 0, accept_cyc = 0;
    bit finished = 0, pulse_chk = 0;
    logic [7:0] exp_q[$];
    bit         expch_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    adc_rd_ctrl #(.T_CNV_HI(P_HI), .T_CNV_LO(P_LO), .T_CONV(P_CONV), .T_SCK_LO(P_SL),
                  .T_SCK_HI(P_SH), .T_GAP(P_GAP), .CNV_IDLE_HIGH(1'b0), .SCK_IDLE_HIGH(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan), .req_ready(rdy_a),
        .rsp_valid(val_a), .rsp_data(dat_a), .rsp_chan(ch_a), .conv_o(conv_a), .sck_o(sck_a),
        .sdi_i(sdi_a));

    adc_rd_ctrl #(.T_CNV_HI(P_HI), .T_CNV_LO(P_LO), .T_CONV(P_CONV), .T_SCK_LO(P_SL),
                  .T_SCK_HI(P_SH), .T_GAP(P_GAP), .CNV_IDLE_HIGH(1'b1), .SCK_IDLE_HIGH(1'b1)) dut_m3 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan), .req_ready(rdy_b),
        .rsp_valid(val_b), .rsp_data(dat_b), .rsp_chan(ch_b), .conv_o(conv_b), .sck_o(sck_b),
        .sdi_i(sdi_b));

    adc_dev_model mdl_a (.clk(clk), .conv(conv_a), .sck(sck_a), .clr(clr), .code0(code0),
        .code1(code1), .sdo(sdi_a), .falls(falls_a), .rises(rises_a), .wait_cyc(wait_a),
        .min_gap(gap_a));
    adc_dev_model mdl_b (.clk(clk), .conv(conv_b), .sck(sck_b), .clr(clr), .code0(code0),
        .code1(code1), .sdo(sdi_b), .falls(falls_b), .rises(rises_b), .wait_cyc(wait_b),
        .min_gap(gap_b));

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: issue one read and push its expected result.
    task automatic do_read(input bit ch, input logic [7:0] c0, input logic [7:0] c1, input bit poke);
        while (!rdy_a) @(negedge clk);
        code0 = c0; code1 = c1;
        req_chan = ch; req_valid = 1'b1;
        exp_q.push_back(ch ? c1 : c0);
        expch_q.push_back(ch);
        @(negedge clk);
        req_valid = 1'b0; accept_cyc = cyc; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        if (poke) begin
            // R9: requests while busy must be ignored.
            req_chan = ~ch; req_valid = 1'b1;
            repeat (20) @(negedge clk);
            chk(!rdy_a && !rdy_b, "R9 ready low while busy", {30'd0, rdy_a, rdy_b}, 0);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: pop expected items as responses appear.
    always @(negedge clk) begin
        if (pulse_chk) begin
            pulse_chk = 0;
            chk(!val_a && !val_b, "R9 valid one cycle", {30'd0, val_a, val_b}, 0);
        end
        if (rst_n && (val_a || val_b)) begin
            if (exp_q.size() == 0) begin
                chk(0, "R9 unexpected response", 1, 0);
            end else begin
                logic [7:0] e;
                bit ech;
                e = exp_q.pop_front();
                ech = expch_q.pop_front();
                pulse_chk = 1;
                chk(val_a && val_b, "R9 both modes respond together", {30'd0, val_a, val_b}, 3);
                chk(dat_a == e, "R7 data idle-low mode", dat_a, e);
                chk(dat_b == e, "R7 data idle-high mode", dat_b, e);
                chk(ch_a == ech && ch_b == ech, "R9 channel tag", {30'd0, ch_a, ch_b}, ech ? 3 : 0);
                chk(cyc - accept_cyc == (ech ? L1 : L0), "R9 latency", cyc - accept_cyc, ech ? L1 : L0);
                if (ech) begin
                    chk(falls_a == 2 && falls_b == 2, "R3 two start falls", falls_a * 10 + falls_b, 22);
                end else begin
                    chk(falls_a == 1 && falls_b == 1, "R2 one start fall", falls_a * 10 + falls_b, 11);
                end
                chk(rises_a == 8 && rises_b == 8, "R6 eight clock rises", rises_a * 10 + rises_b, 88);
                chk(wait_a >= P_CONV, "R5 conversion wait idle-low", wait_a, P_CONV);
                chk(wait_b >= P_CONV, "R5 conversion wait idle-high", wait_b, P_CONV);
                chk(conv_a == 1'b0 && conv_b == 1'b1 && rdy_a && rdy_b, "R10 idle level and ready",
                    {28'd0, conv_a, conv_b, rdy_a, rdy_b}, 7);
                chk(sck_a == 1'b0 && sck_b == 1'b1, "R6 clock idle level", {30'd0, sck_a, sck_b}, 1);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog expired", cyc, 0);
            summary();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state, then just after release.
        chk(rdy_a && rdy_b && !val_a && !val_b, "R1 handshake in reset",
            {28'd0, rdy_a, rdy_b, val_a, val_b}, 12);
        chk(conv_a == 1'b0 && conv_b == 1'b1, "R1 start line idle", {30'd0, conv_a, conv_b}, 1);
        chk(sck_a == 1'b0 && sck_b == 1'b1, "R1 clock idle", {30'd0, sck_a, sck_b}, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rdy_a && rdy_b && !val_a && !val_b && !conv_a && conv_b, "R1 idle after release",
            {26'd0, rdy_a, rdy_b, val_a, val_b, conv_a, conv_b}, 49);

        do_read(1'b0, 8'hA5, 8'h3C, 1'b0);
        do_read(1'b1, 8'h11, 8'hC3, 1'b0);
        do_read(1'b0, 8'h00, 8'hFF, 1'b1);
        do_read(1'b1, 8'hFF, 8'h00, 1'b0);
        do_read(1'b0, 8'h80, 8'h01, 1'b0);
        do_read(1'b1, 8'h7E, 8'h81, 1'b1);
        do_read(1'b0, 8'h01, 8'h80, 1'b0);
        do_read(1'b1, 8'h5A, 8'hA5, 1'b0);
        do_read(1'b0, 8'hFF, 8'h55, 1'b0);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
        // R8: spacing from the last clock edge to the next start-line edge.
        chk(gap_a >= P_GAP, "R8 gap idle-low", gap_a, P_GAP);
        chk(gap_b >= P_GAP, "R8 gap idle-high", gap_b, P_GAP);
        if (!finished) begin
            finished = 1;
            summary();
        end
    end
endmodule